// File: doc/BRIEF.md
# Serial Wire Debug Register Transaction Master

This block is the host side of a two-wire serial debug link. It takes one register access at a time, either to the debug port or to an access port, and carries it out on a clock output and a bidirectional data line with a separate output enable. Each access is described by an 8-bit request byte, a 32-bit write value and a count of trailing idle clocks. The block returns the read data, the three-bit acknowledge from the target and a sticky error status.

The block handles the rest of the access on its own. It turns the line around between host and target and generates and checks parity. When the target answers WAIT, the block clears the target's sticky flags and repeats the access. It also adds idle clocks after access-port operations. After any failure, further requests are skipped until the host issues a flush. The flush clocks the line idle, reports the accumulated error and clears it.

Each link bit takes two system clocks. In the first, the link clock is low, the output data is valid and the input is sampled at the end of that clock. In the second, the link clock is high.

Top module: `swd_txn_master`

## Requirements
- R1: The request byte is sent over 8 link clocks, least significant bit first, with the data line driven. Bit 0 (start) and bit 7 (park) are forced to 1 whatever `req_cmd` holds. Within the byte, bit 1 selects the access port, bit 2 marks a read and bits 4:3 are the register address.
- R2: Each link bit holds `swclk` low for one clock with the data valid, samples `swdio_i` at the end of that clock, then holds `swclk` high for one clock. `swclk` is low whenever no bit is in progress.
- R3: For a read, the line is released for 38 bits: turnaround, 3 acknowledge bits, 32 data bits, parity and turnaround, each field least significant bit first. On completion `rsp_rdata` and `rsp_ack` hold the received values. The acknowledge codes are OK=001, WAIT=010 and FAULT=100.
- R4: For a write, the line is released for 5 bits (turnaround, 3 acknowledge bits, turnaround). It is then driven for 33 bits: the data least significant bit first, then even parity, which is the XOR of the 32 data bits.
- R5: During the fifth released bit of a write, `swdio_o` already carries data bit 0, so `swdio_o` does not change when `swdio_oe` rises.
- R6: A read whose parity bit differs from the XOR of its data sets the sticky error with `err_kind`=2.
- R7: A WAIT acknowledge triggers a debug-port write to address 0 (wire request byte 0x81) with data 0x0000001E, which clears the four sticky flags. The acknowledge of that clearing write is not checked. The original access is then repeated in full.
- R8: When an access collects its 255th WAIT, the block stops retrying and sets the sticky error with `err_kind`=3.
- R9: Any acknowledge other than OK or WAIT sets the sticky error with `err_kind`=1. While the error is set, every request completes with `txn_done` and `txn_skipped` and produces no link clock.
- R10: A debug-port write to address 3 (target select, bits 2:1=00 and 4:3=11) ignores the received acknowledge. It completes without error even when the target answers FAULT.
- R11: After an access-port access that ends without error, `req_ap_idle` further link clocks follow with the line released. Debug-port accesses get none.
- R12: A flush produces 8 link clocks with the line released. It then pulses `flush_done` with `flush_err` equal to the sticky error, and clears both the sticky error and `err_kind`.
- R13: After reset, `swclk`=0, `swdio_oe`=0, `sticky_err`=0, `err_kind`=0, `txn_done`=0 and `req_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_cmd | input | 8 | Request byte |
| req_wdata | input | 32 | Write value |
| req_ap_idle | input | 8 | Idle link clocks after a successful access-port access |
| flush_req | input | 1 | Start a flush (accepted when idle) |
| txn_done | output | 1 | One-clock pulse at the end of a request |
| txn_skipped | output | 1 | With `txn_done`: request skipped because of a sticky error |
| rsp_ack | output | 3 | Last acknowledge received |
| rsp_rdata | output | 32 | Last read data |
| sticky_err | output | 1 | Error latched since the last flush |
| err_kind | output | 2 | 0 none, 1 acknowledge, 2 read parity, 3 retry limit |
| flush_done | output | 1 | One-clock pulse at the end of a flush |
| flush_err | output | 1 | Sticky error value reported by the flush |
| swclk | output | 1 | Link clock |
| swdio_o | output | 1 | Link data output |
| swdio_oe | output | 1 | Link data output enable |
| swdio_i | input | 1 | Link data input |

## Verification
All results of a request are due in the clock where `txn_done` pulses. That pulse comes one clock after the last link bit of the last segment, and the bench samples every response field on the falling edge where it first sees the pulse. The bench's target model answers on the rising edge of `swclk`, two clocks before the host samples the next bit. The number of link clocks for each scenario is worked out ahead of the run: 46 per access attempt, plus 46 for each clearing write, plus the access-port idle count, and 8 for a flush. The bench compares these counts with the rising edges it counts between acceptance and `txn_done`.

// File: rtl/swd_pkg.sv
package swd_pkg;
  localparam logic [2:0]  ACK_OK    = 3'b001;
  localparam logic [2:0]  ACK_WAIT  = 3'b010;
  localparam logic [2:0]  ACK_FAULT = 3'b100;
  localparam logic [7:0]  ABORT_REQ = 8'h81;         // DP write, address 0
  localparam logic [31:0] ABORT_CLR = 32'h0000_001E; // four sticky-clear bits

  typedef enum logic [1:0] {
    ERR_NONE   = 2'd0,
    ERR_ACK    = 2'd1,
    ERR_PARITY = 2'd2,
    ERR_RETRY  = 2'd3
  } err_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_REQ, ST_RDATA, ST_WACK, ST_WDATA, ST_APIDLE, ST_FLUSH
  } ctl_state_e;

  function automatic logic even_par32(input logic [31:0] d);
    return ^d;
  endfunction

  function automatic logic [7:0] wire_byte(input logic [7:0] c);
    return c | 8'h81;
  endfunction

  function automatic logic is_tsel_write(input logic [7:0] c);
    return (c[1] == 1'b0) && (c[2] == 1'b0) && (c[4:3] == 2'b11);
  endfunction
endpackage

// File: rtl/swd_bit_engine.sv
module swd_bit_engine #(
  parameter int SEG_W = 40,
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] len,
  input  logic [SEG_W-1:0] tx,
  input  logic             oe,
  input  logic             swdio_i,
  output logic             busy,
  output logic             done,
  output logic [SEG_W-1:0] rx,
  output logic             swclk,
  output logic             swdio_o,
  output logic             swdio_oe
);
  localparam int IDX_W = $clog2(SEG_W);
  localparam logic [LEN_W-1:0] CAP_LIM = LEN_W'(SEG_W);

  logic             ph;
  logic [LEN_W-1:0] cnt;
  logic [LEN_W-1:0] last;
  logic [SEG_W-1:0] tx_q;

  wire bit_end = busy & ph;
  wire seg_end = bit_end && (cnt == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      ph       <= 1'b0;
      cnt      <= '0;
      last     <= '0;
      tx_q     <= '0;
      rx       <= '0;
      swdio_oe <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy     <= 1'b1;
        ph       <= 1'b0;
        cnt      <= '0;
        last     <= len - 1'b1;
        tx_q     <= tx;
        swdio_oe <= oe;
      end else if (busy) begin
        ph <= ~ph;
        if (!ph && (cnt < CAP_LIM)) rx[cnt[IDX_W-1:0]] <= swdio_i;
        if (seg_end) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else if (bit_end) begin
          cnt  <= cnt + 1'b1;
          tx_q <= tx_q >> 1;
        end
      end
    end
  end

  assign swclk   = busy & ph;
  assign swdio_o = tx_q[0];

  // R2: a new segment is only launched once the previous one has finished
  p_start_when_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
endmodule

// File: rtl/swd_rsp_decode.sv
module swd_rsp_decode #(
  parameter int SEG_W = 40
) (
  input  logic [SEG_W-1:0] rx,
  output logic [2:0]       ack,
  output logic [31:0]      rdata,
  output logic             par_ok
);
  import swd_pkg::*;
  localparam int ACK_POS  = 1;
  localparam int DATA_POS = ACK_POS + 3;
  localparam int PAR_POS  = DATA_POS + 32;

  assign ack    = rx[ACK_POS +: 3];
  assign rdata  = rx[DATA_POS +: 32];
  assign par_ok = (rx[PAR_POS] == even_par32(rdata));
endmodule

// File: rtl/swd_txn_ctrl.sv
module swd_txn_ctrl #(
  parameter int SEG_W      = 40,
  parameter int LEN_W      = 8,
  parameter int WAIT_LIMIT = 255
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [7:0]       req_cmd,
  input  logic [31:0]      req_wdata,
  input  logic [LEN_W-1:0] req_ap_idle,
  input  logic             flush_req,
  output logic             eng_start,
  output logic [LEN_W-1:0] eng_len,
  output logic [SEG_W-1:0] eng_tx,
  output logic             eng_oe,
  input  logic             eng_done,
  input  logic [2:0]       dec_ack,
  input  logic [31:0]      dec_rdata,
  input  logic             dec_par_ok,
  output logic             txn_done,
  output logic             txn_skipped,
  output logic [2:0]       rsp_ack,
  output logic [31:0]      rsp_rdata,
  output logic             sticky_err,
  output logic [1:0]       err_kind,
  output logic             flush_done,
  output logic             flush_err,
  output logic             req_fire,
  output logic             wdata_seg
);
  import swd_pkg::*;
  localparam int REQ_BITS  = 8;
  localparam int RD_BITS   = 38;
  localparam int WACK_BITS = 5;
  localparam int WD_BITS   = 33;
  localparam int FL_BITS   = 8;
  localparam int WC_W      = $clog2(WAIT_LIMIT + 1);
  localparam logic [WC_W-1:0] WAIT_LAST = WC_W'(WAIT_LIMIT - 1);

  ctl_state_e       st;
  logic [7:0]       cmd_q;
  logic [31:0]      wdata_q;
  logic [LEN_W-1:0] idle_q;
  logic [WC_W-1:0]  wait_cnt;
  logic             in_abort;
  logic [2:0]       ack_q;

  wire [7:0]  act_cmd   = in_abort ? ABORT_REQ : cmd_q;
  wire [31:0] act_wdata = in_abort ? ABORT_CLR : wdata_q;
  wire        resolve   = eng_done && ((st == ST_RDATA) || (st == ST_WDATA));
  wire [2:0]  cur_ack   = (st == ST_RDATA) ? dec_ack : ack_q;
  wire        ack_ign   = (st == ST_WDATA) && is_tsel_write(cmd_q);
  wire        par_bad   = (st == ST_RDATA) && !dec_par_ok;

  assign req_ready = (st == ST_IDLE) && !flush_req;
  assign req_fire  = req_valid && req_ready;
  assign wdata_seg = (st == ST_WDATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE;
      cmd_q <= '0; wdata_q <= '0; idle_q <= '0; wait_cnt <= '0;
      in_abort <= 1'b0; ack_q <= '0;
      eng_start <= 1'b0; eng_len <= '0; eng_tx <= '0; eng_oe <= 1'b0;
      txn_done <= 1'b0; txn_skipped <= 1'b0; rsp_ack <= '0; rsp_rdata <= '0;
      sticky_err <= 1'b0; err_kind <= ERR_NONE; flush_done <= 1'b0; flush_err <= 1'b0;
    end else begin
      eng_start   <= 1'b0;
      txn_done    <= 1'b0;
      txn_skipped <= 1'b0;
      flush_done  <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (flush_req) begin
            eng_start <= 1'b1; eng_len <= LEN_W'(FL_BITS); eng_tx <= '0; eng_oe <= 1'b0;
            st <= ST_FLUSH;
          end else if (req_valid) begin
            if (sticky_err) begin
              txn_done    <= 1'b1;
              txn_skipped <= 1'b1;
            end else begin
              cmd_q <= req_cmd; wdata_q <= req_wdata; idle_q <= req_ap_idle;
              wait_cnt <= '0; in_abort <= 1'b0;
              eng_start <= 1'b1; eng_len <= LEN_W'(REQ_BITS);
              eng_tx <= SEG_W'(wire_byte(req_cmd)); eng_oe <= 1'b1;
              st <= ST_REQ;
            end
          end
        end
        ST_REQ: if (eng_done) begin
          eng_start <= 1'b1; eng_oe <= 1'b0;
          if (act_cmd[2]) begin
            eng_len <= LEN_W'(RD_BITS); eng_tx <= '0;
            st <= ST_RDATA;
          end else begin
            // first data bit preloaded into the last released bit
            eng_len <= LEN_W'(WACK_BITS); eng_tx <= SEG_W'({act_wdata[0], 4'b0000});
            st <= ST_WACK;
          end
        end
        ST_WACK: if (eng_done) begin
          ack_q <= dec_ack;
          eng_start <= 1'b1; eng_len <= LEN_W'(WD_BITS); eng_oe <= 1'b1;
          eng_tx <= SEG_W'({even_par32(act_wdata), act_wdata});
          st <= ST_WDATA;
        end
        ST_APIDLE: if (eng_done) begin
          txn_done <= 1'b1;
          st <= ST_IDLE;
        end
        ST_FLUSH: if (eng_done) begin
          flush_done <= 1'b1;
          flush_err  <= sticky_err;
          sticky_err <= 1'b0;
          err_kind   <= ERR_NONE;
          st <= ST_IDLE;
        end
        default: ;
      endcase

      if (resolve) begin
        if (in_abort) begin
          // clearing write done: repeat the original access, ack unchecked
          in_abort <= 1'b0;
          eng_start <= 1'b1; eng_len <= LEN_W'(REQ_BITS);
          eng_tx <= SEG_W'(wire_byte(cmd_q)); eng_oe <= 1'b1;
          st <= ST_REQ;
        end else begin
          rsp_ack <= cur_ack;
          if (st == ST_RDATA) rsp_rdata <= dec_rdata;
          if (ack_ign || (cur_ack == ACK_OK)) begin
            if (par_bad) begin
              sticky_err <= 1'b1; err_kind <= ERR_PARITY;
              txn_done <= 1'b1; st <= ST_IDLE;
            end else if (cmd_q[1] && (idle_q != '0)) begin
              eng_start <= 1'b1; eng_len <= idle_q; eng_tx <= '0; eng_oe <= 1'b0;
              st <= ST_APIDLE;
            end else begin
              txn_done <= 1'b1; st <= ST_IDLE;
            end
          end else if (cur_ack == ACK_WAIT) begin
            if (wait_cnt == WAIT_LAST) begin
              sticky_err <= 1'b1; err_kind <= ERR_RETRY;
              txn_done <= 1'b1; st <= ST_IDLE;
            end else begin
              wait_cnt <= wait_cnt + 1'b1;
              in_abort <= 1'b1;
              eng_start <= 1'b1; eng_len <= LEN_W'(REQ_BITS);
              eng_tx <= SEG_W'(wire_byte(ABORT_REQ)); eng_oe <= 1'b1;
              st <= ST_REQ;
            end
          end else begin
            sticky_err <= 1'b1; err_kind <= ERR_ACK;
            txn_done <= 1'b1; st <= ST_IDLE;
          end
        end
      end
    end
  end

  // R9: a request arriving with a sticky error completes as skipped next cycle
  p_skip_when_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fire && sticky_err) |=> (txn_done && txn_skipped));
  // R12: the sticky error only ever clears through a flush
  p_clear_by_flush_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sticky_err) |-> flush_done);
  // R12: request completion and flush completion never coincide
  p_done_exclusive_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({txn_done, flush_done}));
endmodule

// File: rtl/swd_txn_master.sv
module swd_txn_master #(
  parameter int SEG_W      = 40,
  parameter int LEN_W      = 8,
  parameter int WAIT_LIMIT = 255
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [7:0]       req_cmd,
  input  logic [31:0]      req_wdata,
  input  logic [LEN_W-1:0] req_ap_idle,
  input  logic             flush_req,
  output logic             txn_done,
  output logic             txn_skipped,
  output logic [2:0]       rsp_ack,
  output logic [31:0]      rsp_rdata,
  output logic             sticky_err,
  output logic [1:0]       err_kind,
  output logic             flush_done,
  output logic             flush_err,
  output logic             swclk,
  output logic             swdio_o,
  output logic             swdio_oe,
  input  logic             swdio_i
);
  logic             eng_start, eng_oe, eng_done, eng_busy;
  logic [LEN_W-1:0] eng_len;
  logic [SEG_W-1:0] eng_tx, eng_rx;
  logic [2:0]       dec_ack;
  logic [31:0]      dec_rdata;
  logic             dec_par_ok;
  logic             req_fire, wdata_seg;

  swd_bit_engine #(.SEG_W(SEG_W), .LEN_W(LEN_W)) u_engine (
    .clk(clk), .rst_n(rst_n), .start(eng_start), .len(eng_len), .tx(eng_tx),
    .oe(eng_oe), .swdio_i(swdio_i), .busy(eng_busy), .done(eng_done), .rx(eng_rx),
    .swclk(swclk), .swdio_o(swdio_o), .swdio_oe(swdio_oe));

  swd_rsp_decode #(.SEG_W(SEG_W)) u_decode (
    .rx(eng_rx), .ack(dec_ack), .rdata(dec_rdata), .par_ok(dec_par_ok));

  swd_txn_ctrl #(.SEG_W(SEG_W), .LEN_W(LEN_W), .WAIT_LIMIT(WAIT_LIMIT)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_cmd(req_cmd), .req_wdata(req_wdata), .req_ap_idle(req_ap_idle),
    .flush_req(flush_req), .eng_start(eng_start), .eng_len(eng_len), .eng_tx(eng_tx),
    .eng_oe(eng_oe), .eng_done(eng_done), .dec_ack(dec_ack), .dec_rdata(dec_rdata),
    .dec_par_ok(dec_par_ok), .txn_done(txn_done), .txn_skipped(txn_skipped),
    .rsp_ack(rsp_ack), .rsp_rdata(rsp_rdata), .sticky_err(sticky_err),
    .err_kind(err_kind), .flush_done(flush_done), .flush_err(flush_err),
    .req_fire(req_fire), .wdata_seg(wdata_seg));

  // R5: enabling the driver for write data leaves the output level unchanged
  p_no_glitch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wdata_seg && $rose(swdio_oe)) |-> $stable(swdio_o));
  // R9: a skipped request starts no link activity
  p_skip_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fire && sticky_err) |=> !eng_busy);
endmodule

// File: tb/swd_txn_master_bench.sv
module swd_txn_master_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [7:0] req_cmd = '0;
  logic [31:0] req_wdata = '0;
  logic [7:0] req_ap_idle = '0;
  logic flush_req = 1'b0;
  logic swdio_i = 1'b0;
  logic req_ready, txn_done, txn_skipped, sticky_err, flush_done, flush_err;
  logic [2:0] rsp_ack;
  logic [31:0] rsp_rdata;
  logic [1:0] err_kind;
  logic swclk, swdio_o, swdio_oe;

  always #2.5 clk = ~clk;

  swd_txn_master u_swd_txn_master (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_cmd(req_cmd), .req_wdata(req_wdata), .req_ap_idle(req_ap_idle),
    .flush_req(flush_req), .txn_done(txn_done), .txn_skipped(txn_skipped),
    .rsp_ack(rsp_ack), .rsp_rdata(rsp_rdata), .sticky_err(sticky_err),
    .err_kind(err_kind), .flush_done(flush_done), .flush_err(flush_err),
    .swclk(swclk), .swdio_o(swdio_o), .swdio_oe(swdio_oe), .swdio_i(swdio_i));

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;
  bit wd_expired = 1'b0;
  int unsigned rises = 0;
  int unsigned base = 0;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) wd_expired = 1'b1;
  end
  always @(posedge swclk) rises++;

  // ---------------- target model ----------------
  int unsigned t_phase = 0, t_cnt = 0, t_j = 0;
  logic [7:0]  t_req = '0;
  logic        t_rnw = 1'b0, t_abort = 1'b0, t_wpar = 1'b0, t_pre = 1'b0;
  logic [2:0]  t_ack = '0;
  logic [31:0] t_wdata = '0;
  logic [7:0]  cap_req = '0;
  logic [31:0] cap_wdata = '0, abort_data = '0;
  logic        cap_wpar = 1'b0, cap_pre = 1'b0;
  int unsigned n_user = 0, n_abort = 0, wait_until = 0;
  logic [2:0]  tgt_ack = 3'b001;
  logic [31:0] tgt_rdata = '0;
  logic        tgt_bad_par = 1'b0;

  function automatic logic rbit(input int unsigned j);
    if (j >= 1 && j <= 3) return t_ack[j-1];
    if (t_rnw && j >= 4 && j <= 35) return tgt_rdata[j-4];
    if (t_rnw && j == 36) return (^tgt_rdata) ^ tgt_bad_par;
    return 1'b0;
  endfunction

  always @(posedge swclk) begin
    if (t_phase == 0) begin
      if (swdio_oe && swdio_o) begin t_req = 8'h01; t_cnt = 1; t_phase = 1; end
    end else if (t_phase == 1) begin
      t_req[t_cnt] = swdio_o;
      t_cnt++;
      if (t_cnt == 8) begin
        t_rnw = t_req[2];
        t_abort = (t_req == 8'h81);
        if (t_abort) begin t_ack = 3'b001; n_abort++; end
        else begin
          cap_req = t_req;
          t_ack = (n_user < wait_until) ? 3'b010 : tgt_ack;
          n_user++;
        end
        t_j = 0; t_phase = 2; swdio_i = 1'b1;
      end
    end else begin
      if (!t_rnw) begin
        if (t_j == 4) t_pre = swdio_o;
        if (t_j >= 5 && t_j <= 36) t_wdata[t_j-5] = swdio_o;
        if (t_j == 37) t_wpar = swdio_o;
      end
      t_j++;
      if (t_j == 38) begin
        t_phase = 0; swdio_i = 1'b0;
        if (!t_rnw) begin
          if (t_abort) abort_data = t_wdata;
          else begin cap_wdata = t_wdata; cap_wpar = t_wpar; cap_pre = t_pre; end
        end
      end else swdio_i = rbit(t_j);
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [7:0] c, input logic [31:0] w, input logic [7:0] idl);
    @(negedge clk);
    base = rises;
    req_cmd = c; req_wdata = w; req_ap_idle = idl; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (!txn_done && !wd_expired) @(negedge clk);
  endtask

  task automatic flush();
    @(negedge clk);
    base = rises;
    flush_req = 1'b1;
    @(negedge clk);
    flush_req = 1'b0;
    while (!flush_done && !wd_expired) @(negedge clk);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset_state();
    chk("R13 swclk", swclk, 0);
    chk("R13 swdio_oe", swdio_oe, 0);
    chk("R13 sticky", sticky_err, 0);
    chk("R13 err_kind", err_kind, 0);
    chk("R13 txn_done", txn_done, 0);
    chk("R13 req_ready", req_ready, 1);
  endtask

  task automatic t_read_dp();
    tgt_ack = 3'b001; tgt_rdata = 32'hA5C3_1F06; tgt_bad_par = 1'b0;
    issue(8'h0C, 32'h0, 8'd4);
    chk("R1 wire byte start/park forced", cap_req, 8'h8D);
    chk("R3 read data", rsp_rdata, 32'hA5C3_1F06);
    chk("R3 ack", rsp_ack, 3'b001);
    chk("R11 DP read has no idle clocks", rises - base, 46);
    chk("R2 swclk low after done", swclk, 0);
    chk("R6 no error on good parity", sticky_err, 0);
  endtask

  task automatic t_read_ap();
    tgt_rdata = 32'h1234_5678;
    issue(8'h1E, 32'h0, 8'd4);
    chk("R3 AP read data", rsp_rdata, 32'h1234_5678);
    chk("R11 AP idle clocks", rises - base, 50);
    chk("R1 AP wire byte", cap_req, 8'h9F);
  endtask

  task automatic t_write(input logic [31:0] w);
    issue(8'h30, w, 8'd0);
    chk("R4 write data", cap_wdata, w);
    chk("R4 write parity", cap_wpar, ^w);
    chk("R5 preload bit", cap_pre, w[0]);
    chk("R4 bit count", rises - base, 46);
    chk("R4 ack", rsp_ack, 3'b001);
  endtask

  task automatic t_wait_retry();
    int unsigned a0;
    a0 = n_abort;
    tgt_rdata = 32'hDEAD_0001;
    wait_until = n_user + 2;
    issue(8'h0C, 32'h0, 8'd0);
    chk("R7 clearing writes", n_abort - a0, 2);
    chk("R7 clearing data", abort_data, 32'h0000_001E);
    chk("R7 total clocks", rises - base, 230);
    chk("R7 data after retry", rsp_rdata, 32'hDEAD_0001);
    chk("R7 no sticky", sticky_err, 0);
  endtask

  task automatic t_tsel();
    tgt_ack = 3'b100;
    issue(8'h18, 32'h0000_0042, 8'd0);
    chk("R10 not skipped", txn_skipped, 0);
    chk("R10 no sticky", sticky_err, 0);
    chk("R10 ack reported", rsp_ack, 3'b100);
    chk("R10 data sent", cap_wdata, 32'h0000_0042);
    tgt_ack = 3'b001;
  endtask

  task automatic t_fault_skip_flush();
    tgt_ack = 3'b100;
    issue(8'h22, 32'h5555_AAAA, 8'd3);
    chk("R9 sticky on FAULT", sticky_err, 1);
    chk("R9 err_kind ack", err_kind, 1);
    chk("R11 no idle after failed AP", rises - base, 46);
    tgt_ack = 3'b001;
    issue(8'h0C, 32'h0, 8'd0);
    chk("R9 skipped flag", txn_skipped, 1);
    chk("R9 no link clocks", rises - base, 0);
    flush();
    chk("R12 flush clocks", rises - base, 8);
    chk("R12 flush_err", flush_err, 1);
    chk("R12 sticky cleared", sticky_err, 0);
    chk("R12 err_kind cleared", err_kind, 0);
    chk("R12 line released", swdio_oe, 0);
  endtask

  task automatic t_junk();
    tgt_ack = 3'b111;
    issue(8'h0C, 32'h0, 8'd0);
    chk("R9 junk ack kind", err_kind, 1);
    tgt_ack = 3'b001;
    flush();
  endtask

  task automatic t_parity();
    tgt_rdata = 32'h0F0F_0001; tgt_bad_par = 1'b1;
    issue(8'h0C, 32'h0, 8'd0);
    chk("R6 sticky on bad parity", sticky_err, 1);
    chk("R6 err_kind parity", err_kind, 2);
    tgt_bad_par = 1'b0;
    flush();
    chk("R12 flush reports parity error", flush_err, 1);
  endtask

  task automatic t_retry_limit();
    int unsigned u0, a0;
    u0 = n_user; a0 = n_abort;
    wait_until = n_user + 1000;
    issue(8'h0C, 32'h0, 8'd0);
    chk("R8 attempts", n_user - u0, 255);
    chk("R8 clearing writes", n_abort - a0, 254);
    chk("R8 err_kind retry", err_kind, 3);
    wait_until = 0;
    flush();
  endtask

  task automatic t_clean_flush();
    flush();
    chk("R12 clean flush_err", flush_err, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    @(negedge clk);
    t_read_dp();
    t_read_ap();
    t_write(32'h8000_0003);
    t_write(32'h0000_0006);
    t_wait_retry();
    t_tsel();
    t_fault_skip_flush();
    t_junk();
    t_parity();
    t_retry_limit();
    t_clean_flush();
    if (wd_expired) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule